// File: doc/BRIEF.md
# Ethernet PHY Mode Control Register

This block holds the top-level mode word of a 10/100 Ethernet physical-layer transceiver. A station manager reaches it through a simple single-cycle register port. The port has an address, write data, a write strobe and read data, and a read returns data in the same cycle. The word carries a software reset, loopback, a link speed, an auto-negotiation switch, power-down, isolation from the MII, a request to restart negotiation, and the duplex setting.

The two self-clearing requests are handed to neighbouring engines and read back as set until those engines answer. The software reset goes to a reset sequencer, which answers with a done pulse. The restart goes to the negotiation engine, which answers when it has started. While negotiation is on, the speed and duplex that are read back and driven out are the negotiated ones and not the written ones.

The block also gates the MII data path. Isolation releases every MII output to high impedance and blocks the transmit inputs. Power-down drives the MII outputs to a steady low. Entering loopback at 100 Mbps blanks a receive-valid qualifier for a configurable dead time, which stands for the time the descrambler needs to regain lock.

Top module: `phy_mode_ctl`

## Requirements
- R1: After a hardware reset the mode word at address 0 reads 16'h3000 when the negotiated inputs are speed 1 and duplex 0. In that state auto-negotiation is on, restart is 0, reset is 0, and loopback, power-down, isolate and written duplex are 0. The written speed is 1.
- R2: Only address 0 is decoded. A read at any other address returns 0, and a write at any other address changes nothing.
- R3: A write to address 0 with bit 15 set returns every field to its R1 default. Bit 15 and rst_req then stay 1 until the cycle in which rst_done is 1. All writes are ignored while the reset is pending.
- R4: A write to address 0 with bit 9 and bit 12 set makes bit 9 and an_restart_req read 1 until an an_started cycle. A later write that keeps bit 12 at 1 and clears bit 9 does not cancel the request.
- R5: While auto-negotiation is off (bit 12 = 0), bit 9 and an_restart_req are 0, and a write that sets bit 9 has no effect.
- R6: Bit 13 is speed (1 = 100 Mbps) and bit 8 is duplex (1 = full). Bit 12 enables negotiation, bit 11 is power-down, bit 10 is isolate and bit 14 is loopback. While bit 12 is 1, bits 13 and 8 and the ctl_speed_100 and ctl_full_dup outputs follow an_speed_100 and an_full_dup. Otherwise they follow the written values.
- R7: Bits 7 to 0 always read 0.
- R8: While isolate is 1, every MII pin output is high impedance and mii_oe is 0. txd_q, tx_en_q and tx_er_q are 0 whatever the transmit inputs do, and register reads and writes keep working.
- R9: While power-down is 1 and isolate is 0, every MII pin output is driven to a constant 0 and the qualified transmit outputs are 0. Register reads and writes keep working.
- R10: With isolate and power-down both 0, every MII pin output and every qualified transmit output equals its core or pin input.
- R11: When loopback goes from 0 to 1 while the effective speed is 100 Mbps, rx_valid_qual is 0 for LB_DEAD_CYC+1 cycles, starting with the cycle after the write. It then returns to 1.
- R12: ctl_loopback mirrors bit 14. A loopback entry at 10 Mbps leaves rx_valid_qual at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| mgmt_addr | input | ADDR_W | Register address |
| mgmt_wdata | input | 16 | Write data |
| mgmt_we | input | 1 | Write strobe |
| mgmt_rdata | output | 16 | Combinational read data |
| rst_req | output | 1 | Software reset request to the sequencer |
| rst_done | input | 1 | Sequencer finished the reset |
| an_restart_req | output | 1 | Restart request to the negotiation engine |
| an_started | input | 1 | Negotiation engine has started |
| an_speed_100 | input | 1 | Negotiated speed, 1 = 100 Mbps |
| an_full_dup | input | 1 | Negotiated duplex, 1 = full |
| ctl_an_en | output | 1 | Negotiation enabled |
| ctl_speed_100 | output | 1 | Effective speed |
| ctl_full_dup | output | 1 | Effective duplex |
| ctl_loopback | output | 1 | Loopback enabled |
| ctl_pwr_down | output | 1 | Power-down enabled |
| core_tx_clk | input | 1 | Transmit clock from the core |
| core_rx_clk | input | 1 | Receive clock from the core |
| core_rxd | input | MII_DW | Receive data from the core |
| core_rx_dv | input | 1 | Receive data valid from the core |
| core_rx_er | input | 1 | Receive error from the core |
| core_col | input | 1 | Collision from the core |
| core_crs | input | 1 | Carrier sense from the core |
| mii_tx_clk | output | 1 | MII transmit clock pin |
| mii_rx_clk | output | 1 | MII receive clock pin |
| mii_rxd | output | MII_DW | MII receive data pins |
| mii_rx_dv | output | 1 | MII receive valid pin |
| mii_rx_er | output | 1 | MII receive error pin |
| mii_col | output | 1 | MII collision pin |
| mii_crs | output | 1 | MII carrier sense pin |
| mii_oe | output | 1 | Output enable of the MII pins |
| mii_txd | input | MII_DW | MII transmit data pins |
| mii_tx_en | input | 1 | MII transmit enable pin |
| mii_tx_er | input | 1 | MII transmit error pin |
| txd_q | output | MII_DW | Qualified transmit data |
| tx_en_q | output | 1 | Qualified transmit enable |
| tx_er_q | output | 1 | Qualified transmit error |
| rx_valid_qual | output | 1 | Receive-valid qualifier, 0 during loopback dead time |

## Verification
The checker watches several properties on every cycle:
- the pending reset and restart requests hold until answered;
- restart is absent while negotiation is off;
- the negotiated speed and duplex are passed through;
- the reserved bits stay at zero;
- the transmit path is blocked under isolation;
- the pins stay quiet under power-down;
- the receive qualifier drops at a 100 Mbps loopback entry.

The bench's scenarios are needed to show the rest. Those are the exact reset word, the address decode, the full dead-time length and its return to valid, the absence of blanking at 10 Mbps, and writes being ignored during a pending reset. They also cover the pass-through in normal mode, and a clearing write that fails to cancel a restart.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;

  // Bit positions of the mode word (the manager software decodes these)
  localparam int B_RST     = 15;
  localparam int B_LB      = 14;
  localparam int B_SPEED   = 13;
  localparam int B_AN_EN   = 12;
  localparam int B_PD      = 11;
  localparam int B_ISO     = 10;
  localparam int B_RESTART = 9;
  localparam int B_DUP     = 8;

  typedef struct packed {
    logic lb;
    logic speed;
    logic an_en;
    logic pd;
    logic iso;
    logic dup;
  } mode_fields_t;

  localparam mode_fields_t FIELD_DEFAULTS = '{lb: 1'b0, speed: 1'b1, an_en: 1'b1,
                                              pd: 1'b0, iso: 1'b0, dup: 1'b0};

  // Negotiated value wins while negotiation is on
  function automatic logic eff_sel(input logic an_on, input logic negotiated,
                                   input logic written);
    return an_on ? negotiated : written;
  endfunction

  // Assemble the read word; low byte reserved as zero
  function automatic logic [15:0] pack_word(input mode_fields_t f, input logic rst_p,
                                            input logic an_p, input logic neg_spd,
                                            input logic neg_dup);
    logic [15:0] w;
    w            = '0;
    w[B_RST]     = rst_p;
    w[B_LB]      = f.lb;
    w[B_SPEED]   = eff_sel(f.an_en, neg_spd, f.speed);
    w[B_AN_EN]   = f.an_en;
    w[B_PD]      = f.pd;
    w[B_ISO]     = f.iso;
    w[B_RESTART] = an_p;
    w[B_DUP]     = eff_sel(f.an_en, neg_dup, f.dup);
    return w;
  endfunction

endpackage

// File: rtl/phy_ctl_regfile.sv
module phy_ctl_regfile
  import phy_ctl_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [15:0]  wdata,
  input  logic         rst_done,
  input  logic         an_started,
  output mode_fields_t fields,
  output logic         rst_pend,
  output logic         an_pend,
  output logic         sw_rst_evt,
  output logic         an_req_set
);

  mode_fields_t fields_n;
  logic         rst_pend_n;
  logic         an_pend_n;
  logic         unused_wd;

  assign unused_wd  = ^wdata[7:0];
  assign sw_rst_evt = wr_hit && !rst_pend && wdata[B_RST];
  assign an_req_set = wr_hit && !rst_pend && !wdata[B_RST]
                      && wdata[B_RESTART] && wdata[B_AN_EN];

  always_comb begin
    fields_n   = fields;
    rst_pend_n = rst_pend;
    an_pend_n  = an_pend;
    if (rst_pend) begin
      // fields already at defaults; writes are ignored until done
      if (rst_done) rst_pend_n = 1'b0;
      an_pend_n = 1'b0;
    end else if (sw_rst_evt) begin
      fields_n   = FIELD_DEFAULTS;
      rst_pend_n = 1'b1;
      an_pend_n  = 1'b0;
    end else begin
      if (wr_hit) begin
        fields_n.lb    = wdata[B_LB];
        fields_n.speed = wdata[B_SPEED];
        fields_n.an_en = wdata[B_AN_EN];
        fields_n.pd    = wdata[B_PD];
        fields_n.iso   = wdata[B_ISO];
        fields_n.dup   = wdata[B_DUP];
      end
      if (an_started)      an_pend_n = 1'b0;
      if (an_req_set)      an_pend_n = 1'b1;
      if (!fields_n.an_en) an_pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields   <= FIELD_DEFAULTS;
      rst_pend <= 1'b0;
      an_pend  <= 1'b0;
    end else begin
      fields   <= fields_n;
      rst_pend <= rst_pend_n;
      an_pend  <= an_pend_n;
    end
  end

endmodule

// File: rtl/phy_lb_blank.sv
module phy_lb_blank #(
  parameter int LB_DEAD_CYC = 18_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lb_on,
  input  logic speed_100,
  output logic lb_rise,
  output logic rx_valid_qual
);

  localparam int CW = (LB_DEAD_CYC < 1) ? 1 : $clog2(LB_DEAD_CYC + 1);

  logic          lb_prev;
  logic [CW-1:0] dead_cnt;
  logic          blank_start;

  assign lb_rise       = lb_on && !lb_prev;
  assign blank_start   = lb_rise && speed_100;
  assign rx_valid_qual = (dead_cnt == '0) && !blank_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_prev  <= 1'b0;
      dead_cnt <= '0;
    end else begin
      lb_prev <= lb_on;
      if (blank_start)          dead_cnt <= CW'(LB_DEAD_CYC);
      else if (dead_cnt != '0)  dead_cnt <= dead_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/phy_mii_gate.sv
module phy_mii_gate #(
  parameter int MII_DW = 4
) (
  input  logic              iso,
  input  logic              pd,
  input  logic [MII_DW+5:0] core_bus,
  output logic [MII_DW+5:0] drv_bus,
  output logic              oe,
  input  logic [MII_DW-1:0] tx_d,
  input  logic              tx_en,
  input  logic              tx_er,
  output logic [MII_DW-1:0] tx_d_q,
  output logic              tx_en_q,
  output logic              tx_er_q
);

  logic pass;

  assign oe   = !iso;
  assign pass = !iso && !pd;

  for (genvar i = 0; i < MII_DW + 6; i++) begin : g_out
    assign drv_bus[i] = pass && core_bus[i];
  end

  for (genvar j = 0; j < MII_DW; j++) begin : g_tx
    assign tx_d_q[j] = pass && tx_d[j];
  end

  assign tx_en_q = pass && tx_en;
  assign tx_er_q = pass && tx_er;

endmodule

// File: rtl/phy_mode_ctl.sv
module phy_mode_ctl
  import phy_ctl_pkg::*;
#(
  parameter int          ADDR_W      = 5,
  parameter int          MII_DW      = 4,
  parameter int          LB_DEAD_CYC = 18_000_000,
  parameter logic [4:0]  REG_ADDR    = 5'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mgmt_addr,
  input  logic [15:0]       mgmt_wdata,
  input  logic              mgmt_we,
  output logic [15:0]       mgmt_rdata,
  output logic              rst_req,
  input  logic              rst_done,
  output logic              an_restart_req,
  input  logic              an_started,
  input  logic              an_speed_100,
  input  logic              an_full_dup,
  output logic              ctl_an_en,
  output logic              ctl_speed_100,
  output logic              ctl_full_dup,
  output logic              ctl_loopback,
  output logic              ctl_pwr_down,
  input  logic              core_tx_clk,
  input  logic              core_rx_clk,
  input  logic [MII_DW-1:0] core_rxd,
  input  logic              core_rx_dv,
  input  logic              core_rx_er,
  input  logic              core_col,
  input  logic              core_crs,
  output logic              mii_tx_clk,
  output logic              mii_rx_clk,
  output logic [MII_DW-1:0] mii_rxd,
  output logic              mii_rx_dv,
  output logic              mii_rx_er,
  output logic              mii_col,
  output logic              mii_crs,
  output logic              mii_oe,
  input  logic [MII_DW-1:0] mii_txd,
  input  logic              mii_tx_en,
  input  logic              mii_tx_er,
  output logic [MII_DW-1:0] txd_q,
  output logic              tx_en_q,
  output logic              tx_er_q,
  output logic              rx_valid_qual
);

  localparam int BUS_W = MII_DW + 6;

  // Named internal events, visible to the bound checker
  logic         wr_hit;
  logic         sw_rst_evt;
  logic         an_req_set;
  logic         lb_rise_w;
  mode_fields_t fields;
  logic         rst_pend;
  logic         an_pend;
  logic [BUS_W-1:0] core_bus;
  logic [BUS_W-1:0] drv_bus;

  assign wr_hit = mgmt_we && (mgmt_addr == ADDR_W'(REG_ADDR));

  phy_ctl_regfile i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hit     (wr_hit),
    .wdata      (mgmt_wdata),
    .rst_done   (rst_done),
    .an_started (an_started),
    .fields     (fields),
    .rst_pend   (rst_pend),
    .an_pend    (an_pend),
    .sw_rst_evt (sw_rst_evt),
    .an_req_set (an_req_set)
  );

  assign mgmt_rdata     = (mgmt_addr == ADDR_W'(REG_ADDR))
                          ? pack_word(fields, rst_pend, an_pend, an_speed_100, an_full_dup)
                          : 16'h0000;
  assign rst_req        = rst_pend;
  assign an_restart_req = an_pend;
  assign ctl_an_en      = fields.an_en;
  assign ctl_speed_100  = eff_sel(fields.an_en, an_speed_100, fields.speed);
  assign ctl_full_dup   = eff_sel(fields.an_en, an_full_dup, fields.dup);
  assign ctl_loopback   = fields.lb;
  assign ctl_pwr_down   = fields.pd;

  phy_lb_blank #(.LB_DEAD_CYC(LB_DEAD_CYC)) i_blank (
    .clk           (clk),
    .rst_n         (rst_n),
    .lb_on         (fields.lb),
    .speed_100     (ctl_speed_100),
    .lb_rise       (lb_rise_w),
    .rx_valid_qual (rx_valid_qual)
  );

  assign core_bus = {core_tx_clk, core_rx_clk, core_rx_dv, core_rx_er,
                     core_col, core_crs, core_rxd};

  phy_mii_gate #(.MII_DW(MII_DW)) i_gate (
    .iso      (fields.iso),
    .pd       (fields.pd),
    .core_bus (core_bus),
    .drv_bus  (drv_bus),
    .oe       (mii_oe),
    .tx_d     (mii_txd),
    .tx_en    (mii_tx_en),
    .tx_er    (mii_tx_er),
    .tx_d_q   (txd_q),
    .tx_en_q  (tx_en_q),
    .tx_er_q  (tx_er_q)
  );

  assign mii_tx_clk = mii_oe ? drv_bus[MII_DW+5] : 1'bz;
  assign mii_rx_clk = mii_oe ? drv_bus[MII_DW+4] : 1'bz;
  assign mii_rx_dv  = mii_oe ? drv_bus[MII_DW+3] : 1'bz;
  assign mii_rx_er  = mii_oe ? drv_bus[MII_DW+2] : 1'bz;
  assign mii_col    = mii_oe ? drv_bus[MII_DW+1] : 1'bz;
  assign mii_crs    = mii_oe ? drv_bus[MII_DW]   : 1'bz;
  assign mii_rxd    = mii_oe ? drv_bus[MII_DW-1:0] : {MII_DW{1'bz}};

endmodule

// File: rtl/phy_mode_ctl_chk.sv
module phy_mode_ctl_chk #(
  parameter int MII_DW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       mgmt_wdata,
  input logic [15:0]       mgmt_rdata,
  input logic              wr_hit,
  input logic              rst_req,
  input logic              rst_done,
  input logic              an_restart_req,
  input logic              an_started,
  input logic              an_speed_100,
  input logic              an_full_dup,
  input logic              ctl_an_en,
  input logic              ctl_speed_100,
  input logic              ctl_full_dup,
  input logic              ctl_loopback,
  input logic              ctl_pwr_down,
  input logic              mii_oe,
  input logic              mii_rx_dv,
  input logic              mii_rx_er,
  input logic              mii_col,
  input logic              mii_crs,
  input logic              mii_tx_clk,
  input logic              mii_rx_clk,
  input logic [MII_DW-1:0] mii_rxd,
  input logic [MII_DW-1:0] txd_q,
  input logic              tx_en_q,
  input logic              tx_er_q,
  input logic              lb_rise_w,
  input logic              rx_valid_qual
);

  AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req && !rst_done |=> rst_req);  // R3

  AST_RST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> ctl_an_en && !ctl_loopback && !ctl_pwr_down && mii_oe);  // R3

  AST_AN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart_req && !an_started && !rst_req
      && !(wr_hit && (!mgmt_wdata[12] || mgmt_wdata[15])) |=> an_restart_req);  // R4

  AST_AN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_an_en |-> !an_restart_req);  // R5

  AST_NEG_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_an_en |-> (ctl_speed_100 == an_speed_100) && (ctl_full_dup == an_full_dup));  // R6

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_rdata[7:0] == 8'h00);  // R7

  AST_ISO_TX_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !mii_oe |-> !tx_en_q && !tx_er_q && (txd_q == '0));  // R8

  AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_pwr_down && mii_oe |-> (mii_rx_dv === 1'b0) && (mii_rx_er === 1'b0)
      && (mii_col === 1'b0) && (mii_crs === 1'b0) && (mii_tx_clk === 1'b0)
      && (mii_rx_clk === 1'b0) && (mii_rxd === '0));  // R9

  AST_LB_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    lb_rise_w && ctl_speed_100 |=> !rx_valid_qual);  // R11

endmodule

bind phy_mode_ctl phy_mode_ctl_chk #(.MII_DW(MII_DW)) i_chk (.*);

// File: tb/test_phy_mode_ctl.sv
module test_phy_mode_ctl;

  localparam int DEAD = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mgmt_addr = '0;
  logic [15:0] mgmt_wdata = '0;
  logic        mgmt_we = 1'b0;
  logic        rst_done = 1'b0, an_started = 1'b0;
  logic        an_speed_100 = 1'b1, an_full_dup = 1'b0;
  logic        core_tx_clk = 1'b0, core_rx_clk = 1'b0, core_rx_dv = 1'b0;
  logic        core_rx_er = 1'b0, core_col = 1'b0, core_crs = 1'b0;
  logic [3:0]  core_rxd = '0, mii_txd = '0;
  logic        mii_tx_en = 1'b0, mii_tx_er = 1'b0;

  logic [15:0] mgmt_rdata;
  logic        rst_req, an_restart_req, ctl_an_en, ctl_speed_100, ctl_full_dup;
  logic        ctl_loopback, ctl_pwr_down, mii_oe, tx_en_q, tx_er_q, rx_valid_qual;
  logic [3:0]  txd_q;
  wire         mii_tx_clk, mii_rx_clk, mii_rx_dv, mii_rx_er, mii_col, mii_crs;
  wire  [3:0]  mii_rxd;

  int n_checks = 0;
  int n_fail   = 0;

  // Bench model state
  logic m_lb, m_spd, m_an, m_pd, m_iso, m_dup, m_rstp, m_anp, m_lbprev;
  int   m_cnt;

  always #2.5 clk = ~clk;

  phy_mode_ctl #(.LB_DEAD_CYC(DEAD)) i_phy_mode_ctl (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic pick(input logic an, input logic neg, input logic wr);
    if (an) return neg;
    return wr;
  endfunction

  task automatic model_defaults();
    m_lb = 0; m_spd = 1; m_an = 1; m_pd = 0; m_iso = 0; m_dup = 0;
    m_rstp = 0; m_anp = 0;
  endtask

  task automatic check_all();
    logic [15:0] er;
    logic        es, ed, erise, ev;
    logic [9:0]  ebus;
    logic [9:0]  abus;
    es = pick(m_an, an_speed_100, m_spd);
    ed = pick(m_an, an_full_dup, m_dup);
    er = 16'h0;
    if (mgmt_addr == 5'd0)
      er = {m_rstp, m_lb, es, m_an, m_pd, m_iso, m_anp, ed, 8'h00};
    chk("R2 read word", mgmt_rdata, er);
    chk("R3 reset bit/req", {15'h0, rst_req}, {15'h0, m_rstp});
    if (m_an) chk("R4 restart req", {15'h0, an_restart_req}, {15'h0, m_anp});
    else      chk("R5 restart off", {15'h0, an_restart_req}, 16'h0);
    chk("R6 speed/dup/an", {13'h0, ctl_an_en, ctl_speed_100, ctl_full_dup},
        {13'h0, m_an, es, ed});
    chk("R7 reserved", {8'h0, mgmt_rdata[7:0]}, 16'h0);
    chk("R12 loopback out", {14'h0, ctl_loopback, ctl_pwr_down}, {14'h0, m_lb, m_pd});
    abus = {mii_tx_clk, mii_rx_clk, mii_rx_dv, mii_rx_er, mii_col, mii_crs, mii_rxd};
    if (m_iso) begin
      ebus = 10'bzzzzzzzzzz;
      chk("R8 isolate pins", {6'h0, abus}, {6'h0, ebus});
      chk("R8 isolate tx", {9'h0, mii_oe, txd_q, tx_en_q, tx_er_q}, 16'h0);
    end else if (m_pd) begin
      chk("R9 power-down pins", {6'h0, abus}, 16'h0);
      chk("R9 power-down tx", {9'h0, mii_oe, txd_q, tx_en_q, tx_er_q}, 16'h0040);
    end else begin
      ebus = {core_tx_clk, core_rx_clk, core_rx_dv, core_rx_er, core_col, core_crs, core_rxd};
      chk("R10 pass pins", {6'h0, abus}, {6'h0, ebus});
      chk("R10 pass tx", {9'h0, mii_oe, txd_q, tx_en_q, tx_er_q},
          {9'h0, 1'b1, mii_txd, mii_tx_en, mii_tx_er});
    end
    erise = m_lb && !m_lbprev && es;
    ev = (m_cnt == 0) && !erise;
    if (erise || m_cnt != 0) chk("R11 dead time", {15'h0, rx_valid_qual}, {15'h0, ev});
    else                     chk("R12 valid", {15'h0, rx_valid_qual}, {15'h0, ev});
  endtask

  task automatic model_update();
    logic wr, es, rise;
    wr   = mgmt_we && (mgmt_addr == 5'd0);
    es   = pick(m_an, an_speed_100, m_spd);
    rise = m_lb && !m_lbprev;
    if (rise && es) m_cnt = DEAD;
    else if (m_cnt > 0) m_cnt = m_cnt - 1;
    m_lbprev = m_lb;
    if (m_rstp) begin
      if (rst_done) m_rstp = 0;
      m_anp = 0;
    end else if (wr && mgmt_wdata[15]) begin
      model_defaults();
      m_rstp = 1;
    end else begin
      if (wr) begin
        m_lb = mgmt_wdata[14]; m_spd = mgmt_wdata[13]; m_an = mgmt_wdata[12];
        m_pd = mgmt_wdata[11]; m_iso = mgmt_wdata[10]; m_dup = mgmt_wdata[8];
      end
      if (an_started) m_anp = 0;
      if (wr && mgmt_wdata[9] && mgmt_wdata[12]) m_anp = 1;
      if (!m_an) m_anp = 0;
    end
  endtask

  task automatic step(input logic [4:0] a, input logic [15:0] wd, input logic we,
                      input logic rdn, input logic ans, input logic nsp, input logic ndp);
    @(negedge clk);
    mgmt_addr = a; mgmt_wdata = wd; mgmt_we = we;
    rst_done = rdn; an_started = ans; an_speed_100 = nsp; an_full_dup = ndp;
    {core_tx_clk, core_rx_clk, core_rx_dv, core_rx_er, core_col, core_crs} = 6'($urandom);
    core_rxd = 4'($urandom); mii_txd = 4'($urandom);
    {mii_tx_en, mii_tx_er} = 2'($urandom);
    #1;
    check_all();
    model_update();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(5'd0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    model_defaults(); m_lbprev = 0; m_cnt = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset word with negotiated speed 1, duplex 0
    step(5'd0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R1 reset word", mgmt_rdata, 16'h3000);
    // R2 write elsewhere ignored, read elsewhere zero
    step(5'd3, 16'h4C00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R2 other addr", mgmt_rdata, 16'h0);
    idle(2);
    // R4 restart held across a write that clears bit 9
    step(5'd0, 16'h1200, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    step(5'd0, 16'h1000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R4 pending after set", {15'h0, an_restart_req}, 16'h1);
    step(5'd0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R4 not cancelled by clear", {15'h0, an_restart_req}, 16'h1);
    step(5'd0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    idle(1);
    // R5 restart with negotiation off
    step(5'd0, 16'h0200, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    idle(2);
    // R3 software reset, writes ignored while pending
    step(5'd0, 16'h8000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    step(5'd0, 16'h4C00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R3 pending word", mgmt_rdata, 16'hB000);
    step(5'd0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    step(5'd0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R3 done, write ignored", mgmt_rdata, 16'h3000);
    // R11 loopback at 100 Mbps (negotiation off, speed written 1)
    step(5'd0, 16'h6000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    idle(DEAD + 4);
    step(5'd0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    // R12 loopback at 10 Mbps
    step(5'd0, 16'h4000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    idle(3);
    // R8 isolate, R9 power-down
    step(5'd0, 16'h0400, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    idle(4);
    step(5'd0, 16'h0800, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    idle(4);
    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] wd;
      logic [4:0]  a;
      wd = 16'($urandom) & 16'h7FFF;
      if (($urandom % 20) == 0) wd[15] = 1'b1;
      a = (($urandom % 4) == 0) ? 5'($urandom) : 5'd0;
      step(a, wd, (($urandom % 3) == 0), (($urandom % 8) == 0),
           (($urandom % 6) == 0), 1'($urandom), 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule